// File: doc/BRIEF.md
# NVM Checksum Verify and Update Engine

This engine walks the leading region of a word-addressed nonvolatile memory and forms a 16-bit sum of its words. Addition wraps modulo 2^16. The region ends at a fixed checksum word, whose address is a parameter (0x3F by default). A valid image is one whose words, with the checksum word included, sum to the signature 0xBABA.

The engine talks to a memory agent through one request channel and one response channel. The request channel carries the address, a write flag and the write data under a valid/ready handshake. The response channel returns read data and an error bit. The engine keeps only one request outstanding and waits for its response before it moves to the next address.

A start pulse launches one of two operations:
- **Verify** sums every word from address 0 through the checksum word and reports pass or fail.
- **Update** sums the words below the checksum word and then writes the signature minus that sum into the checksum word, so that a later verify passes.

Completion is a one-cycle done pulse. The pass, fail and error flags stay valid until the next accepted start.

Top module: `nvm_csum_engine`

## Requirements
- R1: While reset is applied and after its release, before any start, `req_valid_o`, `busy_o`, `done_o`, `pass_o`, `fail_o` and `err_o` are all 0.
- R2: Reads go to addresses 0, 1, 2 and upward in order, with `req_write_o` = 0. After a request is accepted, no new request is raised until its response has arrived.
- R3: In verify mode (`mode_i` = 0) exactly CSUM_ADDR+1 words are read (0 through CSUM_ADDR). `pass_o` is set when their wrapped sum equals 0xBABA.
- R4: In verify mode, when the wrapped sum of words 0 through CSUM_ADDR differs from 0xBABA, `fail_o` is set and `pass_o` stays 0.
- R5: In update mode (`mode_i` = 1) exactly CSUM_ADDR words are read. Then one write (`req_write_o` = 1) goes to address CSUM_ADDR with data 0xBABA minus the wrapped sum of those words. A successful write response sets `pass_o`, and a following verify passes.
- R6: A read response with `rsp_err_i` = 1 ends the operation at once. `err_o` is set, no further request of any kind is issued, and in update mode no write happens.
- R7: In update mode, a write response with `rsp_err_i` = 1 sets `fail_o`, not `err_o`.
- R8: `done_o` is high for exactly one cycle per operation. In that cycle exactly one of `pass_o`, `fail_o` and `err_o` is 1, and the flags hold their values until the next accepted start, which clears them.
- R9: A start pulse that arrives while `busy_o` is 1 is ignored. The running operation keeps its mode, its read count and its single done pulse.
- R10: While `req_valid_o` is 1 and `req_ready_i` is 0, the request's address, write flag and data stay unchanged on the following cycle.
- R11: Sums that exceed 16 bits wrap, and both the verify comparison and the update write data use the low 16 bits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 1 | 0 = verify, 1 = update; sampled with start |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by the memory agent |
| req_write_o | output | 1 | 1 = write request, 0 = read request |
| req_addr_o | output | ADDR_W | Word address of the request |
| req_wdata_o | output | DATA_W | Write data |
| rsp_valid_i | input | 1 | Response valid (one cycle) |
| rsp_rdata_i | input | DATA_W | Read data |
| rsp_err_i | input | 1 | Response error |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation succeeded |
| fail_o | output | 1 | Checksum mismatch or failed write |
| err_o | output | 1 | Read error abort |

## Verification
The bench builds the engine with ADDR_W = 6 and CSUM_ADDR = 7. Each operation therefore takes only eight reads, which leaves room to vary several things across the same checksum position:
- response latency;
- a stalling request-ready signal;
- error injection at the first word, at the last word an update reads and at the checksum word itself.

A fill of 0xF00D in every word drives the sum past 16 bits many times over. An update followed by an unchanged verify closes the loop between the two modes.

// File: rtl/nvm_csum_pkg.sv
package nvm_csum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4
  } csum_state_t;

  typedef enum logic {
    OP_VERIFY = 1'b0,
    OP_UPDATE = 1'b1
  } csum_op_t;

endpackage

// File: rtl/nvm_csum_rst_sync.sv
module nvm_csum_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nvm_csum_addr_ctr.sv
module nvm_csum_addr_ctr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr_i)      addr_d = '0;
    else if (inc_i) addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               addr_q <= '0;
    else if (clr_i || inc_i)  addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/nvm_csum_accum.sv
module nvm_csum_accum #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] sum_next_o
);
  logic [DATA_W-1:0] sum_q, sum_d;

  assign sum_next_o = sum_q + word_i;

  always_comb begin
    sum_d = sum_q;
    if (clr_i)      sum_d = '0;
    else if (add_i) sum_d = sum_next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             sum_q <= '0;
    else if (clr_i || add_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/nvm_csum_engine.sv
module nvm_csum_engine
  import nvm_csum_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CSUM_ADDR = 'h3F,
  parameter logic [15:0] SIGNATURE = 16'hBABA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  input  logic              rsp_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] CSUM_A   = ADDR_W'(CSUM_ADDR);
  localparam logic [ADDR_W-1:0] UPD_LAST = (CSUM_ADDR == 0) ? '0 : ADDR_W'(CSUM_ADDR - 1);
  localparam logic [DATA_W-1:0] SIG_W    = DATA_W'(SIGNATURE);
  localparam bit                UPD_NONE = (CSUM_ADDR == 0);

  logic rst_q;

  csum_state_t st_q, st_d;
  csum_op_t    op_q, op_d;
  logic done_q, done_d, pass_q, pass_d, fail_q, fail_d, err_q, err_d;
  logic ctr_clr, ctr_inc, acc_clr, acc_add;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] sum_q, sum_next;

  nvm_csum_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q)
  );

  nvm_csum_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst_n(rst_q), .clr_i(ctr_clr), .inc_i(ctr_inc), .addr_o(rd_addr)
  );

  nvm_csum_accum #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_q), .clr_i(acc_clr), .add_i(acc_add),
    .word_i(rsp_rdata_i), .sum_o(sum_q), .sum_next_o(sum_next)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    fail_d  = fail_q;
    err_d   = err_q;
    ctr_clr = 1'b0;
    ctr_inc = 1'b0;
    acc_clr = 1'b0;
    acc_add = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          op_d    = csum_op_t'(mode_i);
          pass_d  = 1'b0;
          fail_d  = 1'b0;
          err_d   = 1'b0;
          ctr_clr = 1'b1;
          acc_clr = 1'b1;
          st_d    = (mode_i && UPD_NONE) ? ST_WR_REQ : ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        if (req_ready_i) st_d = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            err_d  = 1'b1;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            acc_add = 1'b1;
            if (op_q == OP_VERIFY && rd_addr == CSUM_A) begin
              pass_d = (sum_next == SIG_W);
              fail_d = (sum_next != SIG_W);
              done_d = 1'b1;
              st_d   = ST_IDLE;
            end else if (op_q == OP_UPDATE && rd_addr == UPD_LAST) begin
              st_d = ST_WR_REQ;
            end else begin
              ctr_inc = 1'b1;
              st_d    = ST_RD_REQ;
            end
          end
        end
      end
      ST_WR_REQ: begin
        if (req_ready_i) st_d = ST_WR_WAIT;
      end
      ST_WR_WAIT: begin
        if (rsp_valid_i) begin
          pass_d = !rsp_err_i;
          fail_d = rsp_err_i;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_VERIFY;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      done_q <= done_d;
      pass_q <= pass_d;
      fail_q <= fail_d;
      err_q  <= err_d;
    end
  end

  assign req_valid_o = (st_q == ST_RD_REQ) || (st_q == ST_WR_REQ);
  assign req_write_o = (st_q == ST_WR_REQ);
  assign req_addr_o  = req_write_o ? CSUM_A : rd_addr;
  assign req_wdata_o = req_write_o ? (SIG_W - sum_q) : '0;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign fail_o      = fail_q;
  assign err_o       = err_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid_o && req_ready_i) |=> !req_valid_o); // R2
  AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rst_q)
    req_valid_o |-> (req_addr_o <= CSUM_A)); // R3
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid_o && req_write_o) |-> (req_addr_o == CSUM_A && op_q == OP_UPDATE)); // R5
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_q)
    err_o |-> !req_valid_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o); // R8
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> ($countones({pass_o, fail_o, err_o}) == 1)); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (!done_o && !busy_o) |=> (busy_o || (pass_o == $past(pass_o) && fail_o == $past(fail_o)))); // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) &&
                                       $stable(req_write_o) && $stable(req_wdata_o))); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_q)
    (busy_o && start_i && !rsp_valid_i) |=> busy_o); // R9
endmodule

// File: tb/nvm_csum_engine_test.sv
module nvm_csum_engine_test;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int C  = 7;
  localparam logic [15:0] SIG = 16'hBABA;
  localparam int NVEC = 10;
  // [15] mode, [14:13] fill, [12:11] latency, [10] slow ready, [9] write error, [7:0] error address (FF none)
  localparam logic [15:0] VEC [NVEC] = '{
    16'h60FF, 16'h34FF, 16'hA8FF, 16'hDCFF, 16'h40FF,
    16'h2800, 16'hE406, 16'h92FF, 16'h6807, 16'h80FF
  };

  logic clk, rst_n, start, mode;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic busy, done, pass, fail, err;

  int checks = 0, fails = 0;
  logic [15:0] mem [0:63];
  int lat = 0, err_addr = -1;
  logic slow = 0, wr_err = 0, clear_log = 0;
  int pend_cnt, rd_count, wr_count, order_bad, done_count, after_err;
  logic pending, p_write;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic [7:0] cyc;

  nvm_csum_engine #(.ADDR_W(AW), .DATA_W(DW), .CSUM_ADDR(C), .SIGNATURE(SIG)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata), .rsp_err_i(rsp_err),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_o(fail), .err_o(err)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  assign req_ready = !slow || cyc[0];

  // Memory agent model
  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    rsp_valid <= 1'b0;
    if (clear_log) begin
      rd_count <= 0; wr_count <= 0; order_bad <= 0; done_count <= 0; after_err <= 0;
    end else begin
      if (done) done_count <= done_count + 1;
      if (req_valid && err) after_err <= after_err + 1;
      if (pending) begin
        if (pend_cnt == 0) begin
          pending   <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_rdata <= p_write ? 16'h0 : mem[p_addr];
          rsp_err   <= p_write ? wr_err : (int'(p_addr) == err_addr);
          if (p_write && !wr_err) mem[p_addr] <= p_wdata;
        end else pend_cnt <= pend_cnt - 1;
      end
      if (req_valid && req_ready && !pending) begin
        pending <= 1'b1; pend_cnt <= lat;
        p_addr <= req_addr; p_write <= req_write; p_wdata <= req_wdata;
        if (req_write) wr_count <= wr_count + 1;
        else begin
          if (int'(req_addr) != rd_count) order_bad <= order_bad + 1;
          rd_count <= rd_count + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_to(input int last);
    logic [15:0] s = 16'h0;
    for (int i = 0; i <= last; i++) s = s + mem[i];
    return s;
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < 64; i++) begin
      case (kind)
        0: mem[i] = 16'h0000;
        2: mem[i] = 16'hF00D;
        default: mem[i] = 16'(16'h1357 * (i + 1) + 16'h2A);
      endcase
    end
    if (kind == 3) mem[C] = SIG - sum_to(C - 1);
  endtask

  // Launch one operation; returns the flags seen at the done pulse
  task automatic run_op(input logic m, output logic [2:0] flags, input bit pulse_again);
    int t = 0;
    @(negedge clk); clear_log = 1; @(negedge clk); clear_log = 0;
    mode = m; start = 1; @(negedge clk); start = 0;
    chk(busy && !pass && !fail && !err, "R8 flags cleared by start", {busy, pass, fail, err}, 4'b1000);
    if (pulse_again) begin
      repeat (3) @(negedge clk);
      mode = ~m; start = 1; @(negedge clk); start = 0;
    end
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) begin
      chk(0, "R8 watchdog", 0, 1);
      flags = 3'b000;
    end else begin
      flags = {pass, fail, err};
      @(negedge clk);
      chk(!done, "R8 done one cycle", done, 0);
      repeat (4) @(negedge clk);
      chk({pass, fail, err} == flags && done_count == 1, "R8 flags held, single done",
          {pass, fail, err, 4'(done_count)}, {flags, 4'd1});
    end
  endtask

  initial begin
    logic [2:0] fl, ef;
    logic [15:0] part;
    int span, exp_rd;
    bit hit;
    start = 0; mode = 0; rst_n = 0; pending = 0; pend_cnt = 0; cyc = 0;
    rsp_rdata = 0; rsp_err = 0; p_addr = 0; p_write = 0; p_wdata = 0;
    rd_count = 0; wr_count = 0; order_bad = 0; done_count = 0; after_err = 0;
    fill(1);
    repeat (3) @(negedge clk);
    chk(!req_valid && !busy && !done && !pass && !fail && !err, "R1 in reset",
        {req_valid, busy, done, pass, fail, err}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(!req_valid && !busy && !done && !pass && !fail && !err, "R1 after release",
        {req_valid, busy, done, pass, fail, err}, 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [15:0] v = VEC[k];
      fill(int'(v[14:13]));
      lat = int'(v[12:11]); slow = v[10]; wr_err = v[9];
      err_addr = (v[7:0] == 8'hFF) ? -1 : int'(v[7:0]);
      span = v[15] ? C : C + 1;
      hit = (err_addr >= 0) && (err_addr < span);
      exp_rd = hit ? err_addr + 1 : span;
      part = sum_to(C - 1);
      if (hit) ef = 3'b001;
      else if (!v[15]) ef = (sum_to(C) == SIG) ? 3'b100 : 3'b010;
      else ef = wr_err ? 3'b010 : 3'b100;
      run_op(v[15], fl, 0);
      if (hit) chk(fl == ef && after_err == 0, "R6 read error abort", {fl, 4'(after_err)}, {ef, 4'd0});
      else if (!v[15]) chk(fl == ef, ef[2] ? "R3 verify pass" : "R4/R11 verify fail", fl, ef);
      else chk(fl == ef, wr_err ? "R7 write error is fail" : "R5 update pass", fl, ef);
      chk(rd_count == exp_rd && order_bad == 0, "R2/R3 read count and order",
          rd_count * 256 + order_bad, exp_rd * 256);
      chk(wr_count == ((v[15] && !hit) ? 1 : 0), "R5/R6 write count", wr_count, (v[15] && !hit) ? 1 : 0);
      if (v[15] && !hit && !wr_err)
        chk(mem[C] == SIG - part, "R5/R11 checksum word written", mem[C], SIG - part);
      if (k == 9) begin
        lat = 1; slow = 1; err_addr = -1;
        run_op(0, fl, 0);
        chk(fl == 3'b100, "R5 verify after update", fl, 3'b100);
      end
    end

    // Start while busy: second pulse with the other mode must change nothing
    fill(1); lat = 2; slow = 0; err_addr = -1; wr_err = 0;
    run_op(0, fl, 1);
    chk(fl == 3'b010 && rd_count == C + 1 && wr_count == 0, "R9 start ignored while busy",
        {fl, 8'(rd_count), 4'(wr_count)}, {3'b010, 8'(C + 1), 4'd0});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL R8 global watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule